// File: doc/BRIEF.md
# Two-Wire Serial Memory Slave Engine

This block is the protocol front end of a byte-addressed 256 x 8 serial memory. It oversamples the clock and data lines of a two-wire bus with a fast system clock. It finds start and stop conditions and shifts bytes in and out. It pulls the data line low through an open-drain style enable. A control byte is accepted only when it carries the device code and a chip-select field equal to three strap inputs.

A write command loads the internal word pointer from its second byte. Every later byte goes out to a separate page-buffer and commit engine as a byte-write strobe with address and data. A stop after at least one data byte raises a one-cycle commit request. While that engine reports busy, the slave acknowledges nothing, so a master can poll for completion with repeated control bytes.

Read commands return the byte at the pointer. The pointer is either left from the previous access or loaded by a write command that is cut short by a repeated start. The slave keeps sending consecutive bytes for as long as the master acknowledges. The pointer steps after each byte and wraps at the top of the array.

Top module: `serial_mem_slave`

## Requirements
- R1: A falling data line while the clock line is high is a start; a rising data line while the clock line is high is a stop. A start at any bit position restarts reception with a control byte.
- R2: A control byte is acknowledged only when its bits 7:4 equal 1010 and bits 3:1 equal strap_sel. The acknowledge holds the data line low across the ninth clock high phase. After a mismatch, no byte is acknowledged until the next start.
- R3: While wr_busy is high, no byte is acknowledged (control byte of either direction included) and no wr_strobe is issued.
- R4: In a write command (control bit 0 = 0), the second byte loads the pointer. Each later byte is acknowledged and produces one wr_strobe carrying wr_addr equal to the pointer and wr_data equal to the byte.
- R5: A stop following at least one data byte produces a one-cycle wr_commit. A stop with no data byte, or a repeated start, produces none.
- R6: After a write control byte, a word address and a repeated start, a read control byte (bit 0 = 1) returns first the byte at that address.
- R7: A read command without an address returns the byte at the pointer, which is one past the last location accessed.
- R8: The next sequential byte is sent each time the master acknowledges. After a master non-acknowledge, the data line stays released until the next start or stop.
- R9: The pointer advances by one after every byte read or written, wrapping from 0xFF to 0x00.
- R10: sda_oe rises only while the synchronized clock line is low, one system clock after its falling edge has been detected. It is released on every start and stop.
- R11: Out of reset, sda_oe, wr_strobe and wr_commit are low and the pointer is 0x00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than the bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_in | input | 1 | Bus clock line level |
| sda_in | input | 1 | Bus data line level |
| strap_sel | input | 3 | Chip-select straps compared with control bits 3:1 |
| sda_oe | output | 1 | 1 pulls the data line low |
| mem_addr | output | 8 | Word pointer; read address of the memory array |
| rd_data | input | 8 | Array byte at mem_addr |
| wr_strobe | output | 1 | One-cycle pulse per accepted data byte |
| wr_addr | output | 8 | Address of the strobed byte |
| wr_data | output | 8 | Strobed byte |
| wr_commit | output | 1 | One-cycle request to start the internal write cycle |
| wr_busy | input | 1 | Commit engine is writing; the slave must stay silent |

## Verification
The control byte is swept over all sixteen device codes with fixed straps, and over all 64 pairs of strap value and chip-select field. This separates a code decode from a select decode. Following each mismatch with a valid byte and no start shows that the slave stays deaf. Write, poll, random-read, current-read and sequential-read transfers are placed at 0x40, across the 0xFF to 0x00 wrap and at 0x80. Their results are compared with a shadow memory kept by the bench, which distinguishes a lost pointer load from an off-by-one step or a missing wrap. A start inside a byte and a write ended by a repeated start check recovery, and they check that the commit request stays down.

// File: rtl/sms_pkg.sv
package sms_pkg;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_CTRL,
    PH_ADDR,
    PH_WDAT,
    PH_RDAT
  } phase_t;

  // Control byte decode: device code in the high nibble, straps below it.
  function automatic logic ctrl_hit(input logic [7:0] b,
                                    input logic [3:0] code,
                                    input logic [2:0] strap);
    return (b[7:4] == code) && (b[3:1] == strap);
  endfunction

  // Read direction flag carried in the control byte.
  function automatic logic ctrl_is_read(input logic [7:0] b);
    return b[0];
  endfunction

  // Pointer successor, naturally wrapping at the array top.
  function automatic logic [7:0] ptr_next(input logic [7:0] p);
    return p + 8'd1;
  endfunction

endpackage

// File: rtl/sms_sync.sv
module sms_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_pin,
  input  logic sda_pin,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_evt,
  output logic stop_evt
);
  logic [STAGES-1:0] scl_ff;
  logic [STAGES-1:0] sda_ff;
  logic              scl_q;
  logic              sda_q;

  // Idle bus is high, so reset to ones to avoid phantom edges.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_ff <= '1;
      sda_ff <= '1;
      scl_q  <= 1'b1;
      sda_q  <= 1'b1;
    end else begin
      scl_ff <= {scl_ff[STAGES-2:0], scl_pin};
      sda_ff <= {sda_ff[STAGES-2:0], sda_pin};
      scl_q  <= scl_ff[STAGES-1];
      sda_q  <= sda_ff[STAGES-1];
    end
  end

  assign scl_s     = scl_ff[STAGES-1];
  assign sda_s     = sda_ff[STAGES-1];
  assign scl_rise  = scl_s & ~scl_q;
  assign scl_fall  = ~scl_s & scl_q;
  assign start_evt = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_evt  = scl_s & scl_q & ~sda_q & sda_s;

endmodule

// File: rtl/sms_bitcnt.sv
module sms_bitcnt #(
  parameter int BITS = 8,
  localparam int CW = $clog2(BITS + 2)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          scl_rise,
  input  logic          scl_fall,
  input  logic          start_evt,
  input  logic          stop_evt,
  input  logic          sda_s,
  output logic [CW-1:0] cnt,
  output logic [BITS-1:0] rx_byte,
  output logic          byte_done,
  output logic          ack_rise
);
  localparam logic [CW-1:0] ACK_SLOT = CW'(BITS);
  localparam logic [CW-1:0] END_SLOT = CW'(BITS + 1);
  localparam logic [CW-1:0] LAST_BIT = CW'(BITS - 1);

  logic [BITS-2:0] shreg;

  // cnt counts clock rises in the frame: 1..BITS after data bits,
  // END_SLOT after the acknowledge rise; the following fall reopens a byte.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt   <= '0;
      shreg <= '0;
    end else if (start_evt || stop_evt) begin
      cnt <= '0;
    end else if (scl_rise) begin
      if (cnt < ACK_SLOT) begin
        shreg <= {shreg[BITS-3:0], sda_s};
        cnt   <= cnt + 1'b1;
      end else if (cnt == ACK_SLOT) begin
        cnt <= END_SLOT;
      end
    end else if (scl_fall && cnt == END_SLOT) begin
      cnt <= '0;
    end
  end

  assign rx_byte   = {shreg, sda_s};
  assign byte_done = scl_rise && (cnt == LAST_BIT);
  assign ack_rise  = scl_rise && (cnt == ACK_SLOT);

endmodule

// File: rtl/sms_ptr.sv
module sms_ptr (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       load,
  input  logic [7:0] load_val,
  input  logic       step,
  output logic [7:0] ptr
);
  import sms_pkg::*;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    ptr <= 8'h00;
    else if (load) ptr <= load_val;
    else if (step) ptr <= ptr_next(ptr);
  end

endmodule

// File: rtl/serial_mem_slave.sv
module serial_mem_slave #(
  parameter int         SYNC_STAGES = 2,
  parameter logic [3:0] DEV_CODE    = 4'b1010
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_in,
  input  logic       sda_in,
  input  logic [2:0] strap_sel,
  output logic       sda_oe,
  output logic [7:0] mem_addr,
  input  logic [7:0] rd_data,
  output logic       wr_strobe,
  output logic [7:0] wr_addr,
  output logic [7:0] wr_data,
  output logic       wr_commit,
  input  logic       wr_busy
);
  import sms_pkg::*;

  localparam int         BITS     = 8;
  localparam int         CW       = $clog2(BITS + 2);
  localparam logic [CW-1:0] ACK_SLOT = CW'(BITS);
  localparam logic [CW-1:0] END_SLOT = CW'(BITS + 1);

  // Named internal events, also watched by the bound checker.
  logic          scl_s, sda_s, scl_rise, scl_fall, start_evt, stop_evt;
  logic [CW-1:0] bit_cnt;
  logic [7:0]    rx_byte;
  logic          byte_done, ack_rise;
  logic          ptr_load, ptr_step, rd_advance;

  phase_t     phase;
  logic       ack_q;     // slave acknowledges the coming slot
  logic       mack;      // master acknowledged the last read byte
  logic       wr_pend;   // data accepted since the write control byte
  logic [7:0] tx;
  logic       drv_val, drv_upd;

  sms_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .scl_pin(scl_in), .sda_pin(sda_in),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_evt(start_evt), .stop_evt(stop_evt)
  );

  sms_bitcnt #(.BITS(BITS)) u_cnt (
    .clk(clk), .rst_n(rst_n), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_evt(start_evt), .stop_evt(stop_evt), .sda_s(sda_s),
    .cnt(bit_cnt), .rx_byte(rx_byte), .byte_done(byte_done), .ack_rise(ack_rise)
  );

  assign rd_advance = scl_fall && (bit_cnt == END_SLOT) && (phase == PH_RDAT) && mack
                      && !start_evt && !stop_evt;
  assign ptr_load   = byte_done && (phase == PH_ADDR) && !wr_busy;
  assign ptr_step   = (byte_done && (phase == PH_WDAT) && !wr_busy) || rd_advance;

  sms_ptr u_ptr (
    .clk(clk), .rst_n(rst_n), .load(ptr_load), .load_val(rx_byte),
    .step(ptr_step), .ptr(mem_addr)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase     <= PH_IDLE;
      ack_q     <= 1'b0;
      mack      <= 1'b0;
      wr_pend   <= 1'b0;
      tx        <= '0;
      drv_val   <= 1'b0;
      drv_upd   <= 1'b0;
      sda_oe    <= 1'b0;
      wr_strobe <= 1'b0;
      wr_addr   <= '0;
      wr_data   <= '0;
      wr_commit <= 1'b0;
    end else begin
      wr_strobe <= 1'b0;
      wr_commit <= 1'b0;
      drv_upd   <= 1'b0;
      if (start_evt) begin
        phase   <= PH_CTRL;
        ack_q   <= 1'b0;
        wr_pend <= 1'b0;
        sda_oe  <= 1'b0;
      end else if (stop_evt) begin
        phase     <= PH_IDLE;
        ack_q     <= 1'b0;
        sda_oe    <= 1'b0;
        wr_commit <= wr_pend;
        wr_pend   <= 1'b0;
      end else begin
        // Line changes one system clock after the detected clock fall.
        if (drv_upd) sda_oe <= drv_val;

        if (byte_done) begin
          case (phase)
            PH_CTRL: begin
              if (ctrl_hit(rx_byte, DEV_CODE, strap_sel) && !wr_busy) begin
                ack_q <= 1'b1;
                mack  <= 1'b1;
                phase <= ctrl_is_read(rx_byte) ? PH_RDAT : PH_ADDR;
              end else begin
                ack_q <= 1'b0;
                phase <= PH_IDLE;
              end
            end
            PH_ADDR: begin
              ack_q <= !wr_busy;
              phase <= wr_busy ? PH_IDLE : PH_WDAT;
            end
            PH_WDAT: begin
              if (!wr_busy) begin
                ack_q     <= 1'b1;
                wr_strobe <= 1'b1;
                wr_addr   <= mem_addr;
                wr_data   <= rx_byte;
                wr_pend   <= 1'b1;
              end else begin
                ack_q <= 1'b0;
                phase <= PH_IDLE;
              end
            end
            default: ack_q <= 1'b0;
          endcase
        end

        if (ack_rise && phase == PH_RDAT) mack <= !sda_s;

        if (scl_fall) begin
          drv_upd <= 1'b1;
          if (bit_cnt == ACK_SLOT) begin
            drv_val <= ack_q && (phase != PH_IDLE);
          end else if (bit_cnt == END_SLOT) begin
            ack_q <= 1'b0;
            if (phase == PH_RDAT && mack) begin
              tx      <= rd_data;
              drv_val <= !rd_data[7];
            end else begin
              drv_val <= 1'b0;
              if (phase == PH_RDAT) phase <= PH_IDLE;
            end
          end else begin
            drv_val <= (phase == PH_RDAT) && !tx[3'd7 - bit_cnt[2:0]];
          end
        end
      end
    end
  end

endmodule

// File: rtl/sms_chk.sv
module sms_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       scl_s,
  input logic       start_evt,
  input logic       stop_evt,
  input logic       sda_oe,
  input logic       wr_busy,
  input logic       wr_strobe,
  input logic       wr_commit,
  input logic [7:0] mem_addr,
  input logic [7:0] wr_addr,
  input logic [3:0] bit_cnt
);

  // R10
  oe_low_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe) |-> !scl_s);

  // R10
  stop_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop_evt |=> !sda_oe);

  // R1
  start_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_evt |=> (!sda_oe && bit_cnt == 4'd0));

  // R5
  commit_on_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_commit |-> $past(stop_evt));

  // R3
  busy_no_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_strobe |-> !$past(wr_busy));

  // R9
  ptr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_strobe |-> (mem_addr == 8'(wr_addr + 8'd1)));

  // R1
  cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bit_cnt <= 4'd9);

endmodule

bind serial_mem_slave sms_chk u_chk (
  .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .start_evt(start_evt),
  .stop_evt(stop_evt), .sda_oe(sda_oe), .wr_busy(wr_busy),
  .wr_strobe(wr_strobe), .wr_commit(wr_commit), .mem_addr(mem_addr),
  .wr_addr(wr_addr), .bit_cnt(bit_cnt)
);

// File: tb/sim_serial_mem_slave.sv
module sim_serial_mem_slave;
  localparam int CLK_PERIOD = 10;
  localparam int Q          = 8;
  localparam int BUSY_CYC   = 1500;
  localparam logic [7:0] CW = 8'hAA;  // code 1010, straps 101, write
  localparam logic [7:0] CR = 8'hAB;  // same, read

  logic clk = 1'b0;
  logic rst_n;
  logic m_scl, m_sda;
  logic [2:0] strap;
  logic sda_oe, wr_strobe, wr_commit, wr_busy;
  logic [7:0] mem_addr, rd_data, wr_addr, wr_data;
  logic sda_line;

  int nchk = 0;
  int nfail = 0;

  logic [7:0] mem [256];
  logic [7:0] refm [256];
  logic [7:0] pa [16];
  logic [7:0] pd [16];
  logic [7:0] sa [32];
  logic [7:0] sd [32];
  int pn, cc, sn, busy_cnt, viol;
  logic drop, oe_prev;

  always #(CLK_PERIOD/2) clk = ~clk;

  assign sda_line = m_sda & ~sda_oe;
  assign rd_data  = mem[mem_addr];
  assign wr_busy  = (busy_cnt != 0);

  serial_mem_slave u0 (
    .clk(clk), .rst_n(rst_n), .scl_in(m_scl), .sda_in(sda_line),
    .strap_sel(strap), .sda_oe(sda_oe), .mem_addr(mem_addr), .rd_data(rd_data),
    .wr_strobe(wr_strobe), .wr_addr(wr_addr), .wr_data(wr_data),
    .wr_commit(wr_commit), .wr_busy(wr_busy)
  );

  // Page-buffer and commit engine model.
  always @(posedge clk) begin
    if (!rst_n) begin
      pn <= 0; cc <= 0; sn <= 0; busy_cnt <= 0;
      for (int i = 0; i < 256; i++) mem[i] <= 8'(i * 7 + 3);
    end else begin
      if (busy_cnt != 0) busy_cnt <= busy_cnt - 1;
      if (drop) pn <= 0;
      else if (wr_strobe) begin
        pa[pn[3:0]] <= wr_addr;
        pd[pn[3:0]] <= wr_data;
        pn <= pn + 1;
      end
      if (wr_strobe) begin
        sa[sn[4:0]] <= wr_addr;
        sd[sn[4:0]] <= wr_data;
        sn <= sn + 1;
      end
      if (wr_commit) begin
        for (int k = 0; k < pn; k++) mem[pa[k]] <= pd[k];
        pn <= 0;
        cc <= cc + 1;
        busy_cnt <= BUSY_CYC;
      end
    end
  end

  // R10 monitor: the enable must never rise while the master holds clock high.
  always @(posedge clk) begin
    if (!rst_n) begin
      viol <= 0; oe_prev <= 1'b0;
    end else begin
      oe_prev <= sda_oe;
      if (sda_oe && !oe_prev && m_scl) viol <= viol + 1;
    end
  end

  task automatic wq(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic bus_start();
    m_sda = 1'b1; wq(Q);
    m_scl = 1'b1; wq(Q);
    m_sda = 1'b0; wq(Q);
    m_scl = 1'b0; wq(2);
  endtask

  task automatic bus_stop();
    m_sda = 1'b0; wq(Q);
    m_scl = 1'b1; wq(Q);
    m_sda = 1'b1; wq(Q);
  endtask

  task automatic send_bit(input bit b);
    m_sda = b; wq(Q);
    m_scl = 1'b1; wq(Q);
    m_scl = 1'b0; wq(2);
  endtask

  task automatic send_byte(input logic [7:0] b, output bit acked);
    for (int i = 7; i >= 0; i--) send_bit(b[i]);
    m_sda = 1'b1; wq(Q);
    m_scl = 1'b1; wq(Q/2);
    acked = !sda_line;
    wq(Q/2);
    m_scl = 1'b0; wq(2);
  endtask

  task automatic recv_byte(input bit give_ack, output logic [7:0] b);
    m_sda = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      wq(Q);
      m_scl = 1'b1; wq(Q/2);
      b[i] = sda_line;
      wq(Q/2);
      m_scl = 1'b0; wq(2);
    end
    m_sda = give_ack ? 1'b0 : 1'b1; wq(Q);
    m_scl = 1'b1; wq(Q);
    m_scl = 1'b0; wq(2);
    m_sda = 1'b1;
  endtask

  task automatic poll_ready(output int nacks, output bit ready);
    bit a;
    nacks = 0; ready = 1'b0;
    for (int p = 0; p < 60 && !ready; p++) begin
      bus_start();
      send_byte(CW, a);
      bus_stop();
      if (a) ready = 1'b1; else nacks++;
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
  endtask

  initial begin
    #(CLK_PERIOD * 190000);
    nchk++; nfail++;
    $display("FAIL watchdog: run did not complete");
    summary();
    $finish;
  end

  initial begin
    bit a, a2, rdy;
    int nk, sn0, cc0;
    logic [7:0] b;
    for (int i = 0; i < 256; i++) refm[i] = 8'(i * 7 + 3);
    m_scl = 1'b1; m_sda = 1'b1; strap = 3'd5; drop = 1'b0; rst_n = 1'b0;
    repeat (5) @(posedge clk);
    #1; rst_n = 1'b1;
    wq(4);

    // R11 reset state
    chk(sda_oe == 1'b0, "R11 sda_oe", sda_oe, 0);
    chk(wr_strobe == 1'b0 && wr_commit == 1'b0, "R11 strobes", {wr_strobe, wr_commit}, 0);
    chk(mem_addr == 8'h00, "R11 pointer", mem_addr, 0);

    // R2 device code sweep with straps fixed at 101
    for (int code = 0; code < 16; code++) begin
      bus_start();
      send_byte({4'(code), 3'd5, 1'b0}, a);
      chk(a == (code == 10), "R2 code", a, code == 10);
      if (!a) begin
        send_byte(CW, a2);
        chk(!a2, "R2 deaf after mismatch", a2, 0);
      end
      bus_stop();
    end

    // R2 strap / chip-select sweep
    for (int s = 0; s < 8; s++) begin
      strap = 3'(s);
      for (int cs = 0; cs < 8; cs++) begin
        bus_start();
        send_byte({4'hA, 3'(cs), 1'b0}, a);
        chk(a == (cs == s), "R2 select", a, cs == s);
        bus_stop();
      end
    end
    strap = 3'd5;
    wq(4);
    chk(cc == 0, "R5 no commit without data", cc, 0);
    chk(sn == 0, "R4 no strobe without data", sn, 0);

    // R4/R5 byte write
    bus_start();
    send_byte(CW, a);    chk(a, "R4 ctrl ack", a, 1);
    send_byte(8'h40, a); chk(a, "R4 addr ack", a, 1);
    send_byte(8'h5C, a); chk(a, "R4 data ack", a, 1);
    bus_stop();
    wq(4);
    refm[8'h40] = 8'h5C;
    chk(sn == 1, "R4 strobe count", sn, 1);
    chk(sa[0] == 8'h40, "R4 strobe addr", sa[0], 8'h40);
    chk(sd[0] == 8'h5C, "R4 strobe data", sd[0], 8'h5C);
    chk(cc == 1, "R5 commit after stop", cc, 1);

    // R3 silence while busy, then ack polling
    bus_start();
    send_byte(CR, a);
    chk(!a, "R3 read ctrl refused while busy", a, 0);
    bus_stop();
    poll_ready(nk, rdy);
    chk(nk >= 1, "R3 polls refused while busy", nk, 1);
    chk(rdy, "R3 ack after busy ends", rdy, 1);

    // R6 random read
    bus_start();
    send_byte(CW, a);
    send_byte(8'h40, a);
    bus_start();
    send_byte(CR, a); chk(a, "R6 read ctrl ack", a, 1);
    recv_byte(1'b0, b);
    bus_stop();
    chk(b == refm[8'h40], "R6 random read", b, refm[8'h40]);

    // R7 current-address read
    bus_start();
    send_byte(CR, a);
    recv_byte(1'b0, b);
    bus_stop();
    chk(b == refm[8'h41], "R7 current read", b, refm[8'h41]);

    // R9/R4 multi-byte write across the pointer wrap
    sn0 = sn;
    bus_start();
    send_byte(CW, a);
    send_byte(8'hFE, a);
    send_byte(8'h11, a);
    send_byte(8'h22, a);
    send_byte(8'h33, a);
    bus_stop();
    wq(4);
    refm[8'hFE] = 8'h11; refm[8'hFF] = 8'h22; refm[8'h00] = 8'h33;
    chk(sn == sn0 + 3, "R4 page strobes", sn, sn0 + 3);
    chk(sa[1] == 8'hFE && sa[2] == 8'hFF, "R9 strobe addrs", {sa[1], sa[2]}, 16'hFEFF);
    chk(sa[3] == 8'h00, "R9 wrap to 00", sa[3], 0);
    poll_ready(nk, rdy);
    chk(rdy, "R3 ready after page", rdy, 1);

    // R8/R9 sequential read across the wrap
    bus_start();
    send_byte(CW, a);
    send_byte(8'hFD, a);
    bus_start();
    send_byte(CR, a);
    for (int i = 0; i < 5; i++) begin
      recv_byte(i != 4, b);
      chk(b == refm[8'(8'hFD + i)], "R8 sequential byte", b, refm[8'(8'hFD + i)]);
    end
    // extra clock after the non-acknowledge: line must stay released
    m_sda = 1'b1; wq(Q);
    m_scl = 1'b1; wq(Q/2);
    chk(sda_line == 1'b1, "R8 released after nack", sda_line, 1);
    wq(Q/2);
    m_scl = 1'b0; wq(2);
    bus_stop();

    // R7/R9 current read continues after the wrap
    bus_start();
    send_byte(CR, a);
    recv_byte(1'b0, b);
    bus_stop();
    chk(b == refm[8'h02], "R7 current after wrap", b, refm[8'h02]);

    // R1 start in the middle of a byte, R5 write cut by repeated start
    bus_start();
    send_bit(1'b1); send_bit(1'b1); send_bit(1'b1);
    bus_start();
    send_byte(CW, a);
    chk(a, "R1 ctrl after mid-byte start", a, 1);
    send_byte(8'h80, a);
    send_byte(8'h77, a);
    chk(sa[4] == 8'h80, "R4 strobe addr 80", sa[4], 8'h80);
    cc0 = cc;
    bus_start();
    send_byte(CR, a);
    recv_byte(1'b0, b);
    bus_stop();
    wq(4);
    chk(b == refm[8'h81], "R6 read after cut write", b, refm[8'h81]);
    chk(cc == cc0, "R5 no commit after repeated start", cc, cc0);
    drop = 1'b1; wq(1); drop = 1'b0;

    // R10 enable never rose while clock high
    chk(viol == 0, "R10 drive phase", viol, 0);
    chk(sda_oe == 1'b0, "R10 released at idle", sda_oe, 0);

    summary();
    $finish;
  end

endmodule